// File: doc/BRIEF.md
# Translation-Miss Exception Entry Unit

This unit carries out the register updates that a small embedded processor core makes when a translation miss forces it into an exception. Two strobes report a miss: one for a data access and one for an instruction fetch. With each strobe come the failing effective address, the address of the responsible instruction, the current machine state word, the current syndrome word and a store flag. A miss is taken only when the matching translation enable in the machine state word is set. When a miss is taken, the unit saves the return address and the old state. It clears a set of state bits that depends on the miss type, updates the fault address and syndrome registers on a data miss, and redirects the program counter. The redirect target is a 16-bit vector prefix joined to a fixed offset for each miss type.

The unit also sorts incoming debug event strobes into a synchronous class and an asynchronous class, one cycle after they arrive.

Reset is asynchronous and active-low. Its release is synchronised inside the unit, so the unit takes its first miss three rising edges after `rst_n` goes high.

Top module: `tlb_miss_entry`

## Requirements
- R1: A taken miss sets `new_pc_o` to `vec_pfx_i` in the upper 16 bits and an offset in the lower 16 bits. The offset is 0x1100 for a data miss and 0x1200 for an instruction miss. All of the taken miss's updates appear together, one rising edge after the strobe is sampled.
- R2: A taken data miss sets `new_state_o` to `state_i` with bits 29..24 cleared (mask 0x3F000000). Bit 29 is wait, 28 external-interrupt enable, 27 user mode, 26 debug-wait, 25 instruction translation and 24 data translation. Critical enable (bit 3), machine-check enable (bit 2), debug enable (bit 1) and every other bit are copied unchanged.
- R3: A taken instruction miss sets `new_state_o` to `state_i` with bits 31..24 cleared (mask 0xFF000000). This adds the two auxiliary-processor bits 31 and 30 to the bits cleared by a data miss. All other bits are copied unchanged.
- R4: On any taken miss, `save_state_o` receives the complete `state_i` as it was before the exception.
- R5: On any taken miss, `save_ret_o` receives `pc_i`, the address of the instruction that caused the miss.
- R6: A taken data miss loads `fault_addr_o` with `ea_i`. A taken instruction miss leaves `fault_addr_o` unchanged.
- R7: A taken data miss loads `synd_o` as follows. Bit 8 takes `store_i`, which the requester drives high for stores, including cache-block store-type operations. Bit 31 (machine check) is copied from `synd_i`. Every other bit is zero. A taken instruction miss leaves `synd_o` unchanged.
- R8: A data strobe is ignored when `state_i` bit 24 is 0, and an instruction strobe is ignored when bit 25 is 0. An ignored strobe leaves all held registers unchanged and `redirect_o` low.
- R9: When both strobes are taken in the same cycle, the instruction miss wins. Every update is then that of an instruction miss alone.
- R10: `dbg_ev_i` bit positions are: 0 branch taken, 1 data address compare, 2 data value compare, 3 instruction address compare, 4 instruction completion, 5 trap, 6 exception, 7 unconditional. One edge after sampling, `dbg_sync_o` is high if any of bits 5..0 was set, and `dbg_async_o` is high if bit 6 or bit 7 was set.
- R11: While reset is asserted, every output is zero.
- R12: `redirect_o` is high for exactly the one cycle after each taken miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmiss_i | input | 1 | Data translation miss strobe |
| imiss_i | input | 1 | Instruction translation miss strobe |
| store_i | input | 1 | Failing data access is store-type |
| ea_i | input | AW | Failing effective address |
| pc_i | input | AW | Address of the instruction behind the miss |
| state_i | input | 32 | Current machine state word |
| synd_i | input | 32 | Current syndrome word |
| vec_pfx_i | input | PFX_W | Vector prefix |
| dbg_ev_i | input | 8 | Debug event strobes |
| redirect_o | output | 1 | Program counter redirect pulse |
| new_pc_o | output | AW | Vector address |
| new_state_o | output | 32 | Machine state after entry |
| save_ret_o | output | AW | Saved return address |
| save_state_o | output | 32 | Saved machine state |
| fault_addr_o | output | AW | Data fault address |
| synd_o | output | 32 | Syndrome after entry |
| dbg_sync_o | output | 1 | Synchronous debug event seen |
| dbg_async_o | output | 1 | Asynchronous debug event seen |

## Verification
The properties assume three things about the inputs:
- They are stable around each rising edge.
- `state_i`, `synd_i` and the addresses are meaningful in any cycle where a strobe is high.
- No strobe arrives while the internal reset is still held.

The stimulus drives every input on the falling edge. It keeps both strobes low through reset and for several cycles after release. It also returns the strobes to zero for at least one cycle after each vector, so that the single-cycle redirect pulse and the hold behaviour can be observed.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int STW = 32;
  typedef logic [STW-1:0] state_t;

  // machine state bit positions
  localparam int B_AUXP = 31;
  localparam int B_AUXX = 30;
  localparam int B_WAIT = 29;
  localparam int B_EXTI = 28;
  localparam int B_USER = 27;
  localparam int B_DBGW = 26;
  localparam int B_ITRN = 25;
  localparam int B_DTRN = 24;
  localparam int B_CRIT = 3;
  localparam int B_MCHK = 2;
  localparam int B_DBGE = 1;

  localparam state_t CLR_DATA = (state_t'(1) << B_WAIT) | (state_t'(1) << B_EXTI)
                              | (state_t'(1) << B_USER) | (state_t'(1) << B_DBGW)
                              | (state_t'(1) << B_ITRN) | (state_t'(1) << B_DTRN);
  localparam state_t CLR_INSTR = CLR_DATA | (state_t'(1) << B_AUXP) | (state_t'(1) << B_AUXX);

  // syndrome bit positions
  localparam int SYN_STORE = 8;
  localparam int SYN_MCHK  = 31;

  localparam logic [15:0] OFS_DATA  = 16'h1100;
  localparam logic [15:0] OFS_INSTR = 16'h1200;

  localparam int DBG_N = 8;
  localparam logic [DBG_N-1:0] DBG_SYNC_MASK  = 8'h3F;
  localparam logic [DBG_N-1:0] DBG_ASYNC_MASK = 8'hC0;

  typedef enum logic [1:0] {MK_NONE = 2'd0, MK_DATA = 2'd1, MK_INSTR = 2'd2} miss_kind_e;
endpackage

// File: rtl/tlbx_rst_sync.sv
module tlbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/tlbx_state_clear.sv
module tlbx_state_clear
  import tlbx_pkg::*;
#(
  parameter bit FOR_INSTR = 1'b0
) (
  input  state_t cur,
  output state_t cleared
);
  generate
    if (FOR_INSTR) begin : g_instr
      assign cleared = cur & ~CLR_INSTR;
    end else begin : g_data
      assign cleared = cur & ~CLR_DATA;
    end
  endgenerate
endmodule

// File: rtl/tlbx_debug_class.sv
module tlbx_debug_class
  import tlbx_pkg::*;
(
  input  logic [DBG_N-1:0] ev,
  output logic             sync_hit,
  output logic             async_hit
);
  assign sync_hit  = |(ev & DBG_SYNC_MASK);
  assign async_hit = |(ev & DBG_ASYNC_MASK);
endmodule

// File: rtl/tlbx_vector_gen.sv
module tlbx_vector_gen
  import tlbx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PFX_W = 16
) (
  input  logic [PFX_W-1:0] pfx,
  input  logic             is_instr,
  output logic [AW-1:0]    vec
);
  localparam int OFS_W = AW - PFX_W;
  localparam logic [OFS_W-1:0] OFS_D = OFS_W'(OFS_DATA);
  localparam logic [OFS_W-1:0] OFS_I = OFS_W'(OFS_INSTR);

  assign vec = {pfx, (is_instr ? OFS_I : OFS_D)};
endmodule

// File: rtl/tlb_miss_entry.sv
module tlb_miss_entry
  import tlbx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PFX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dmiss_i,
  input  logic             imiss_i,
  input  logic             store_i,
  input  logic [AW-1:0]    ea_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [31:0]      state_i,
  input  logic [31:0]      synd_i,
  input  logic [PFX_W-1:0] vec_pfx_i,
  input  logic [7:0]       dbg_ev_i,
  output logic             redirect_o,
  output logic [AW-1:0]    new_pc_o,
  output logic [31:0]      new_state_o,
  output logic [AW-1:0]    save_ret_o,
  output logic [31:0]      save_state_o,
  output logic [AW-1:0]    fault_addr_o,
  output logic [31:0]      synd_o,
  output logic             dbg_sync_o,
  output logic             dbg_async_o
);
  logic rst_q;

  tlbx_rst_sync #(.STAGES(2)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .rst_q(rst_q)
  );

  // miss selection: instruction side first
  miss_kind_e kind;
  always_comb begin
    if (imiss_i && state_i[B_ITRN])      kind = MK_INSTR;
    else if (dmiss_i && state_i[B_DTRN]) kind = MK_DATA;
    else                                 kind = MK_NONE;
  end

  state_t clr_v [2];
  for (genvar g = 0; g < 2; g++) begin : g_clr
    tlbx_state_clear #(.FOR_INSTR(g == 1)) u_clr (
      .cur    (state_i),
      .cleared(clr_v[g])
    );
  end

  logic [AW-1:0] vec_w;
  tlbx_vector_gen #(.AW(AW), .PFX_W(PFX_W)) u_vec (
    .pfx     (vec_pfx_i),
    .is_instr(kind == MK_INSTR),
    .vec     (vec_w)
  );

  logic sync_w, async_w;
  tlbx_debug_class u_dbg (
    .ev       (dbg_ev_i),
    .sync_hit (sync_w),
    .async_hit(async_w)
  );

  // next-state values and clock enables
  logic        take_en, data_en;
  state_t      state_d;
  logic [31:0] synd_d;
  always_comb begin
    take_en = (kind != MK_NONE);
    data_en = (kind == MK_DATA);
    state_d = (kind == MK_INSTR) ? clr_v[1] : clr_v[0];
    synd_d  = '0;
    synd_d[SYN_MCHK]  = synd_i[SYN_MCHK];
    synd_d[SYN_STORE] = store_i;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      redirect_o   <= 1'b0;
      dbg_sync_o   <= 1'b0;
      dbg_async_o  <= 1'b0;
      new_pc_o     <= '0;
      new_state_o  <= '0;
      save_ret_o   <= '0;
      save_state_o <= '0;
      fault_addr_o <= '0;
      synd_o       <= '0;
    end else begin
      redirect_o  <= take_en;
      dbg_sync_o  <= sync_w;
      dbg_async_o <= async_w;
      if (take_en) begin
        new_pc_o     <= vec_w;
        new_state_o  <= state_d;
        save_ret_o   <= pc_i;
        save_state_o <= state_i;
      end
      if (data_en) begin
        fault_addr_o <= ea_i;
        synd_o       <= synd_d;
      end
    end
  end
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk
  import tlbx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PFX_W = 16
) (
  input logic             clk,
  input logic             rst_q,
  input logic             dmiss_i,
  input logic             imiss_i,
  input logic             store_i,
  input logic [31:0]      state_i,
  input logic [PFX_W-1:0] vec_pfx_i,
  input logic [7:0]       dbg_ev_i,
  input logic             redirect_o,
  input logic [AW-1:0]    new_pc_o,
  input logic [31:0]      new_state_o,
  input logic [AW-1:0]    save_ret_o,
  input logic [31:0]      save_state_o,
  input logic [AW-1:0]    fault_addr_o,
  input logic [31:0]      synd_o,
  input logic             dbg_sync_o
);
  localparam int OFS_W = AW - PFX_W;

  logic i_take, d_take;
  assign i_take = imiss_i && state_i[B_ITRN];
  assign d_take = dmiss_i && state_i[B_DTRN] && !i_take;

  // R1
  vector_form_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (i_take || d_take) |=> redirect_o && new_pc_o[AW-1:OFS_W] == $past(vec_pfx_i));

  // R9
  instr_first_chk: assert property (@(posedge clk) disable iff (!rst_q)
    i_take |=> new_pc_o[OFS_W-1:0] == OFS_W'(OFS_INSTR));

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(i_take || d_take) |=> !redirect_o && $stable(save_ret_o) && $stable(new_state_o));

  // R4
  save_state_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (i_take || d_take) |=> save_state_o == $past(state_i));

  // R2
  data_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    d_take |=> (new_state_o & CLR_DATA) == '0 && new_state_o[B_CRIT] == $past(state_i[B_CRIT])
               && new_state_o[B_MCHK] == $past(state_i[B_MCHK]));

  // R6
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    i_take |=> $stable(fault_addr_o) && $stable(synd_o));

  // R7
  store_bit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    d_take |=> synd_o[SYN_STORE] == $past(store_i));

  // R10
  dbg_sync_chk: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> dbg_sync_o == |($past(dbg_ev_i) & DBG_SYNC_MASK));
endmodule

bind tlb_miss_entry tlbx_chk #(.AW(AW), .PFX_W(PFX_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .dmiss_i     (dmiss_i),
  .imiss_i     (imiss_i),
  .store_i     (store_i),
  .state_i     (state_i),
  .vec_pfx_i   (vec_pfx_i),
  .dbg_ev_i    (dbg_ev_i),
  .redirect_o  (redirect_o),
  .new_pc_o    (new_pc_o),
  .new_state_o (new_state_o),
  .save_ret_o  (save_ret_o),
  .save_state_o(save_state_o),
  .fault_addr_o(fault_addr_o),
  .synd_o      (synd_o),
  .dbg_sync_o  (dbg_sync_o)
);

// File: tb/sim_tlb_miss_entry.sv
`timescale 1ns/1ps
module sim_tlb_miss_entry;
  localparam int AW = 32;
  localparam int PFX_W = 16;
  localparam real HALF = 4.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dmiss = 0, imiss = 0, store = 0;
  logic [31:0] ea = 0, pc = 0, state = 0, synd = 0;
  logic [15:0] pfx = 0;
  logic [7:0]  dbg = 0;
  logic        redirect, dsync, dasync;
  logic [31:0] npc, nstate, sret, sstate, faddr, syn;

  always #(HALF) clk = ~clk;

  tlb_miss_entry #(.AW(AW), .PFX_W(PFX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .dmiss_i(dmiss), .imiss_i(imiss), .store_i(store),
    .ea_i(ea), .pc_i(pc), .state_i(state), .synd_i(synd), .vec_pfx_i(pfx),
    .dbg_ev_i(dbg), .redirect_o(redirect), .new_pc_o(npc), .new_state_o(nstate),
    .save_ret_o(sret), .save_state_o(sstate), .fault_addr_o(faddr), .synd_o(syn),
    .dbg_sync_o(dsync), .dbg_async_o(dasync)
  );

  typedef struct packed {
    logic        dm, im, st;
    logic [31:0] state, synd, ea, pc;
    logic [15:0] pfx;
    logic [7:0]  dbg;
    logic [1:0]  kind;   // 0 none, 1 data, 2 instruction
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b1, 32'hFF0A_500F, 32'h8000_0400, 32'h1234_5678, 32'h0000_2000, 16'hABCD, 8'h01, 2'd1},
    '{1'b0, 1'b1, 1'b0, 32'hFF0A_500F, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_3004, 16'h0FF0, 8'h40, 2'd2},
    '{1'b1, 1'b0, 1'b0, 32'h0100_0000, 32'hFFFF_FFFF, 32'h0000_0FFC, 32'h4000_0010, 16'h8000, 8'h24, 2'd1},
    '{1'b1, 1'b0, 1'b1, 32'h0200_000E, 32'h8000_0000, 32'h5555_0000, 32'h0000_5000, 16'h1111, 8'h80, 2'd0},
    '{1'b0, 1'b1, 1'b0, 32'h0100_0000, 32'h0000_0000, 32'h6666_0000, 32'h0000_6000, 16'h2222, 8'hC3, 2'd0},
    '{1'b1, 1'b1, 1'b1, 32'h0300_0006, 32'h8000_0100, 32'h7777_0000, 32'h0000_7008, 16'hFFFF, 8'h10, 2'd2},
    '{1'b1, 1'b1, 1'b1, 32'h0100_0002, 32'h0000_0000, 32'h8888_0004, 32'h0000_800C, 16'h0001, 8'h00, 2'd1},
    '{1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h9999_0000, 32'h0000_9000, 16'h3333, 8'hFF, 2'd0}
  };

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] e_pc = 0, e_state = 0, e_sret = 0, e_sst = 0, e_fa = 0, e_syn = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_held(input string tag);
    chk({tag, " new_pc"},    npc,    e_pc);
    chk({tag, " new_state"}, nstate, e_state);
    chk({tag, " save_ret"},  sret,   e_sret);
    chk({tag, " save_st"},   sstate, e_sst);
    chk({tag, " fault"},     faddr,  e_fa);
    chk({tag, " synd"},      syn,    e_syn);
  endtask

  task automatic chk_zero(input string tag);
    chk({tag, " redirect"}, {31'd0, redirect}, 32'd0);
    chk({tag, " new_pc"}, npc, 32'd0);
    chk({tag, " new_state"}, nstate, 32'd0);
    chk({tag, " save_ret"}, sret, 32'd0);
    chk({tag, " save_st"}, sstate, 32'd0);
    chk({tag, " fault"}, faddr, 32'd0);
    chk({tag, " synd"}, syn, 32'd0);
    chk({tag, " dbg"}, {30'd0, dsync, dasync}, 32'd0);
  endtask

  task automatic idle_inputs();
    dmiss = 0; imiss = 0; store = 0; dbg = 0;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state
    #3;
    chk_zero("R11 reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      dmiss = v.dm; imiss = v.im; store = v.st; state = v.state; synd = v.synd;
      ea = v.ea; pc = v.pc; pfx = v.pfx; dbg = v.dbg;
      @(negedge clk);
      // expected values, from the requirements
      if (v.kind != 2'd0) begin
        e_pc    = {v.pfx, (v.kind == 2'd2) ? 16'h1200 : 16'h1100};                 // R1
        e_state = v.state & ~((v.kind == 2'd2) ? 32'hFF00_0000 : 32'h3F00_0000);   // R2 R3
        e_sret  = v.pc;                                                            // R5
        e_sst   = v.state;                                                         // R4
        if (v.kind == 2'd1) begin
          e_fa  = v.ea;                                                            // R6
          e_syn = (v.synd & 32'h8000_0000) | (32'(v.st) << 8);                     // R7
        end
      end
      chk($sformatf("R1 R8 R9 redirect v%0d", i), {31'd0, redirect}, {31'd0, v.kind != 2'd0});
      chk_held($sformatf("R2 R3 R4 R5 R6 R7 R9 v%0d", i));
      chk($sformatf("R10 sync v%0d", i), {31'd0, dsync}, {31'd0, |(v.dbg & 8'h3F)});
      chk($sformatf("R10 async v%0d", i), {31'd0, dasync}, {31'd0, |(v.dbg & 8'hC0)});
      idle_inputs();
      @(negedge clk);
      // R12 single-cycle pulse, registers hold
      chk($sformatf("R12 pulse end v%0d", i), {31'd0, redirect}, 32'd0);
      chk_held($sformatf("R12 hold v%0d", i));
    end

    // R8 ignored strobe with all other state bits set, but translation enables clear
    dmiss = 1; imiss = 1; store = 1; state = 32'hFCFF_FFFF; ea = 32'hAAAA_AAAA; pc = 32'h0BAD_0000;
    @(negedge clk);
    chk("R8 gated both", {31'd0, redirect}, 32'd0);
    chk_held("R8 gated both");
    idle_inputs();

    // R11 asynchronous reset in the middle of a cycle
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 chk_zero("R11 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_zero("R11 after release");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule